// File: doc/BRIEF.md
# Floating-Point Class Test Unit

The unit takes a single or double-precision operand and decides which of ten IEEE-754 categories it belongs to: signalling NaN, quiet NaN, signed infinity, signed normal, signed subnormal or signed zero. It then compares that category against a caller-supplied class mask. A precision select chooses between the 32-bit layout in the low half of the operand word and the full 64-bit layout. Subnormal operands are classified as they are, and are never treated as zero.

Both outputs are registered. One is a one-hot class vector, kept for debug and tracing. The other is a single match bit that is high when the operand's class bit is present in the mask. Any number of mask bits may be set together, so one test can ask "is this any kind of NaN or infinity". The operand passes through unchanged, and the unit handles one lane only.

Top module: `fpc_class_test`

## Requirements
- R1: While `rst_n` is low, `class_o` is all zeros and `hit_o` is 0.
- R2: The operand, precision and mask present at a rising clock edge (reset released) appear as `class_o`/`hit_o` right after that same edge, one cycle of latency.
- R3: `class_o` is exactly one-hot after every capture. The bit positions are: 0 signalling NaN, 1 quiet NaN, 2 negative infinity, 3 negative normal, 4 negative subnormal, 5 negative zero, 6 positive zero, 7 positive subnormal, 8 positive normal, 9 positive infinity.
- R4: With `dbl_i`=0 the operand is `op_i[31:0]`, with sign at bit 31, exponent at bits 30:23 and fraction at bits 22:0. Bits 63:32 have no effect.
- R5: With `dbl_i`=1 the operand has sign at bit 63, exponent at bits 62:52 and fraction at bits 51:0.
- R6: A NaN (exponent all ones, fraction nonzero) is quiet when the top fraction bit is 1 and signalling when it is 0. Its sign does not change its class.
- R7: An exponent of zero with a nonzero fraction is classed as subnormal (bit 4 or 7) and never as zero.
- R8: `hit_o` is 1 exactly when the captured mask has the bit set at the operand's class position. Several mask bits may be set at once.
- R9: Mask bits 10 and above are ignored. A mask whose only set bits are at or above bit 10 always gives `hit_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 64 | Operand word |
| dbl_i | input | 1 | 1 = double precision, 0 = single in low 32 bits |
| mask_i | input | MASK_W (16) | Class mask, bits 0..9 used |
| class_o | output | 10 | Registered one-hot class of the operand |
| hit_o | output | 1 | Registered class-in-mask result |

## Verification
Every result is due exactly one rising edge after its stimulus is captured. The bench drives new inputs on the falling edge and compares both outputs on the next falling edge against a prediction made from the inputs of the previous falling edge. The reference classifies by comparing the operand's magnitude against the infinity and smallest-normal thresholds, not by decoding fields. A single stage of expected values therefore lines up each comparison with the cycle in which the registered outputs change.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int NCLS = 10;

  typedef enum logic [3:0] {
    CL_SNAN = 4'd0,
    CL_QNAN = 4'd1,
    CL_NINF = 4'd2,
    CL_NNRM = 4'd3,
    CL_NSUB = 4'd4,
    CL_NZER = 4'd5,
    CL_PZER = 4'd6,
    CL_PSUB = 4'd7,
    CL_PNRM = 4'd8,
    CL_PINF = 4'd9
  } cls_e;

  typedef struct packed {
    logic sign;
    logic exp_ones;
    logic exp_zero;
    logic frac_zero;
    logic quiet;
  } fp_fields_t;

  // Map the summarised fields to a class index (R3, R6, R7)
  function automatic cls_e pick_class(fp_fields_t f);
    cls_e c;
    if (f.exp_ones && !f.frac_zero)      c = f.quiet ? CL_QNAN : CL_SNAN;
    else if (f.exp_ones)                 c = f.sign ? CL_NINF : CL_PINF;
    else if (f.exp_zero && f.frac_zero)  c = f.sign ? CL_NZER : CL_PZER;
    else if (f.exp_zero)                 c = f.sign ? CL_NSUB : CL_PSUB;
    else                                 c = f.sign ? CL_NNRM : CL_PNRM;
    return c;
  endfunction
endpackage

// File: rtl/fpc_field_split.sv
module fpc_field_split
  import fpc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output fp_fields_t        fld_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = word_i[WORD_W-2 -: EXP_W];
  assign frac_f = word_i[FRAC_W-1:0];

  assign fld_o.sign      = word_i[WORD_W-1];
  assign fld_o.exp_ones  = &exp_f;
  assign fld_o.exp_zero  = ~|exp_f;
  assign fld_o.frac_zero = ~|frac_f;
  assign fld_o.quiet     = frac_f[FRAC_W-1];
endmodule

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
(
  input  fp_fields_t       fld_i,
  output logic [NCLS-1:0]  onehot_o
);
  cls_e idx;
  assign idx = pick_class(fld_i);

  always_comb begin
    onehot_o = '0;
    onehot_o[idx] = 1'b1;
  end
endmodule

// File: rtl/fpc_match.sv
module fpc_match
  import fpc_pkg::*;
#(
  parameter int MASK_W = 16
) (
  input  logic [NCLS-1:0]   cls_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              hit_o
);
  // Only the low NCLS mask bits take part (R9)
  assign hit_o = |(cls_i & mask_i[NCLS-1:0]);
endmodule

// File: rtl/fpc_class_test.sv
module fpc_class_test
  import fpc_pkg::*;
#(
  parameter int MASK_W = 16,
  parameter int SP_EXP = 8,
  parameter int SP_FRC = 23,
  parameter int DP_EXP = 11,
  parameter int DP_FRC = 52,
  localparam int SP_W  = 1 + SP_EXP + SP_FRC,
  localparam int DP_W  = 1 + DP_EXP + DP_FRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       op_i,
  input  logic              dbl_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [NCLS-1:0]   class_o,
  output logic              hit_o
);
  fp_fields_t        fld_sp, fld_dp, fld_sel;
  logic [NCLS-1:0]   cls_now;
  logic              hit_now;

  fpc_field_split #(.EXP_W(SP_EXP), .FRAC_W(SP_FRC)) u_sp (
    .word_i (op_i[SP_W-1:0]),
    .fld_o  (fld_sp)
  );

  fpc_field_split #(.EXP_W(DP_EXP), .FRAC_W(DP_FRC)) u_dp (
    .word_i (op_i[DP_W-1:0]),
    .fld_o  (fld_dp)
  );

  assign fld_sel = dbl_i ? fld_dp : fld_sp;

  fpc_decode u_dec (
    .fld_i    (fld_sel),
    .onehot_o (cls_now)
  );

  fpc_match #(.MASK_W(MASK_W)) u_match (
    .cls_i  (cls_now),
    .mask_i (mask_i),
    .hit_o  (hit_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_o <= '0;
      hit_o   <= 1'b0;
    end else begin
      class_o <= cls_now;
      hit_o   <= hit_now;
    end
  end
endmodule

// File: rtl/fpc_class_chk.sv
module fpc_class_chk #(
  parameter int MASK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [63:0]       op_i,
  input logic              dbl_i,
  input logic [MASK_W-1:0] mask_i,
  input logic [9:0]        class_o,
  input logic              hit_o
);
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(class_o) == 1);

  a_r8_hit_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> hit_o == |($past(mask_i[9:0]) & class_o));

  a_r9_high_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mask_i[9:0]) == 10'd0) |-> !hit_o);

  a_r6_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dbl_i) && $past(op_i[62:52]) == 11'h7FF
      && $past(op_i[51:0]) != 52'd0)
    |-> (class_o[1:0] != 2'b00 && class_o[1] == $past(op_i[51])));

  a_r7_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dbl_i) && $past(op_i[30:23]) == 8'd0
      && $past(op_i[22:0]) != 23'd0)
    |-> (class_o[4] || class_o[7]));
endmodule

bind fpc_class_test fpc_class_chk #(.MASK_W(MASK_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_i    (op_i),
  .dbl_i   (dbl_i),
  .mask_i  (mask_i),
  .class_o (class_o),
  .hit_o   (hit_o)
);

// File: tb/sim_fpc_class_test.sv
module sim_fpc_class_test;
  localparam int MASK_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [63:0]       op_i = '0;
  logic              dbl_i = 1'b0;
  logic [MASK_W-1:0] mask_i = '0;
  logic [9:0]        class_o;
  logic              hit_o;

  int n_chk = 0;
  int n_bad = 0;
  logic       have_exp = 1'b0;
  logic [9:0] exp_cls;
  logic       exp_hit;
  string      exp_tag;

  always #2 clk = ~clk;

  fpc_class_test #(.MASK_W(MASK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .dbl_i(dbl_i),
    .mask_i(mask_i), .class_o(class_o), .hit_o(hit_o)
  );

  // Magnitude-threshold reference, independent of field decoding
  function automatic logic [9:0] ref_class(logic [63:0] op, logic dbl);
    logic [62:0] mag, inf_mag, min_norm;
    logic        sgn, qb;
    int          idx;
    if (dbl) begin
      mag = op[62:0]; sgn = op[63]; qb = op[51];
      inf_mag = 63'h7FF0_0000_0000_0000; min_norm = 63'h0010_0000_0000_0000;
    end else begin
      mag = {32'd0, op[30:0]}; sgn = op[31]; qb = op[22];
      inf_mag = 63'h7F80_0000; min_norm = 63'h0080_0000;
    end
    if (mag > inf_mag)       idx = qb ? 1 : 0;
    else if (mag == inf_mag) idx = sgn ? 2 : 9;
    else if (mag == 0)       idx = sgn ? 5 : 6;
    else if (mag < min_norm) idx = sgn ? 4 : 7;
    else                     idx = sgn ? 3 : 8;
    return 10'(1) << idx;
  endfunction

  task automatic compare();
    if (have_exp) begin
      n_chk++;
      if (class_o !== exp_cls) begin
        n_bad++;
        $display("FAIL %s class_o actual %b expected %b", exp_tag, class_o, exp_cls);
      end
      n_chk++;
      if (hit_o !== exp_hit) begin
        n_bad++;
        $display("FAIL R8 (%s) hit_o actual %b expected %b", exp_tag, hit_o, exp_hit);
      end
    end
  endtask

  task automatic step(input logic [63:0] op, input logic dbl,
                      input logic [MASK_W-1:0] m, input string tag);
    @(negedge clk);
    compare();
    op_i = op; dbl_i = dbl; mask_i = m;
    exp_cls  = ref_class(op, dbl);
    exp_hit  = |(exp_cls & m[9:0]);
    exp_tag  = tag;
    have_exp = 1'b1;
  endtask

  function automatic logic [63:0] rand_op(logic dbl);
    logic [63:0] r;
    int sel;
    r = {$urandom, $urandom};
    sel = $urandom % 5;
    if (dbl) begin
      if (sel == 0) r[62:52] = '0;
      if (sel == 1) r[62:52] = '1;
      if (sel == 2) begin r[62:52] = '1; r[51:0] = '0; end
      if (sel == 3) begin r[62:52] = '0; r[51:0] = '0; end
    end else begin
      if (sel == 0) r[30:23] = '0;
      if (sel == 1) r[30:23] = '1;
      if (sel == 2) begin r[30:23] = '1; r[22:0] = '0; end
      if (sel == 3) begin r[30:23] = '0; r[22:0] = '0; end
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1: outputs held at zero during reset
    op_i = 64'h7FF8_0000_0000_0000; dbl_i = 1'b1; mask_i = '1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (class_o !== 10'd0 || hit_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs actual %b/%b expected 0/0", class_o, hit_o);
    end
    // R2: release, the first capture appears one edge later
    op_i = 64'h0; dbl_i = 1'b0; mask_i = 16'h0040;
    rst_n = 1'b1;
    exp_cls = 10'h040; exp_hit = 1'b1; exp_tag = "R2"; have_exp = 1'b1;

    // R3: each class directed, single precision
    step(64'h0000_0000_7F80_0001, 1'b0, 16'h0001, "R3");
    step(64'h0000_0000_7FC0_0000, 1'b0, 16'h0002, "R3");
    step(64'h0000_0000_FF80_0000, 1'b0, 16'h0004, "R3");
    step(64'h0000_0000_BF80_0000, 1'b0, 16'h0008, "R3");
    step(64'h0000_0000_8000_0001, 1'b0, 16'h0010, "R3");
    step(64'h0000_0000_8000_0000, 1'b0, 16'h0020, "R3");
    step(64'h0000_0000_0000_0000, 1'b0, 16'h0040, "R3");
    step(64'h0000_0000_007F_FFFF, 1'b0, 16'h0080, "R3");
    step(64'h0000_0000_3F80_0000, 1'b0, 16'h0100, "R3");
    step(64'h0000_0000_7F80_0000, 1'b0, 16'h0200, "R3");
    // R4: upper word garbage has no effect in single mode
    step(64'hFFF0_0000_0000_0000, 1'b0, 16'h0040, "R4");
    step(64'h7FF8_1234_3F80_0000, 1'b0, 16'h0100, "R4");
    // R5: double-precision layout
    step(64'h3FF0_0000_0000_0000, 1'b1, 16'h0100, "R5");
    step(64'hFFF0_0000_0000_0000, 1'b1, 16'h0004, "R5");
    step(64'h0000_0000_7F80_0000, 1'b1, 16'h0080, "R5");
    step(64'h8000_0000_0000_0000, 1'b1, 16'h0020, "R5");
    // R6: NaN quiet/signalling, sign ignored
    step(64'hFFF8_0000_0000_0000, 1'b1, 16'h0002, "R6");
    step(64'hFFF0_0000_0000_0001, 1'b1, 16'h0001, "R6");
    step(64'h7FF4_0000_0000_0000, 1'b1, 16'h0002, "R6");
    step(64'h0000_0000_FFA0_0000, 1'b0, 16'h0001, "R6");
    // R7: smallest subnormals stay subnormal
    step(64'h0000_0000_0000_0001, 1'b1, 16'h0040, "R7");
    step(64'h800F_FFFF_FFFF_FFFF, 1'b1, 16'h0010, "R7");
    step(64'h0000_0000_0000_0001, 1'b0, 16'h00A0, "R7");
    // R8: multi-bit masks
    step(64'h0000_0000_7FC0_0000, 1'b0, 16'h0203, "R8");
    step(64'h0000_0000_3F80_0000, 1'b0, 16'h02FF, "R8");
    // R9: bits above 9 ignored
    step(64'h0000_0000_7FC0_0000, 1'b0, 16'hFC00, "R9");
    step(64'hFFF0_0000_0000_0000, 1'b1, 16'hFC00, "R9");
    step(64'h3FF0_0000_0000_0000, 1'b1, 16'hFD00, "R9");

    // Random sweep in both precisions
    for (int i = 0; i < 400; i++) begin
      logic d;
      d = 1'(i % 2);
      step(rand_op(d), d, 16'($urandom), d ? "R5" : "R4");
    end
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule